// File: doc/BRIEF.md
# Three-Channel Filtered Edge Capture

This unit timestamps signal edges against a free-running 16-bit count supplied from outside. Three independent channels share that count. Each channel picks one of nine pin inputs, brings it into the clock domain through a two-stage synchronizer, and can pass it through a glitch filter. It then looks for the edge kind it was told to watch and copies the timer value into its own capture register. Software uses the difference of two captures to measure a period or a pulse width. Overflow counting and that arithmetic stay in software.

A capture also raises a sticky per-channel flag and a one-cycle event pulse. The flags are combined into one interrupt request. The event pulse is meant for the timer's reload or clear logic, so that with a clear-on-capture timer the captured value is the period directly. The block has no stream interface. Capture registers are plain outputs that a newer capture overwrites; nothing waits for a consumer, so there is no back-pressure.

Top module: `cap3_unit`

## Requirements
- R1: The 4-bit pin select of a channel picks pin input N for codes 0 to 8. Codes 9 to 15 feed a constant low level, so that channel never captures.
- R2: With the filter off, a pin change applied after clock edge k updates the channel's capture register at clock edge k+4. The stored value is the timer value present at that edge.
- R3: The 2-bit edge mode selects the trigger: 00 is falling, 01 is rising, 10 is both edges, and 11 disables capture. An edge of the wrong kind leaves the register and the flag unchanged.
- R4: While a channel's enable is low, its edges cause no capture, no flag and no event.
- R5: With the filter on, a new level is accepted only after it has held for 4 consecutive synchronized clocks. A pulse shorter than 4 clocks is dropped. An accepted change applied after edge k captures at edge k+7.
- R6: A capture sets the channel flag. Only the channel's clear input resets the flag. When a set and a clear fall on the same edge, the set wins.
- R7: The interrupt request is high exactly when at least one flag is set and both the capture interrupt enable and the global enable are high.
- R8: The event pulse of a channel is high for the single cycle in which its capture register takes the new value.
- R9: A capture overwrites the register even while the channel's flag is still pending.
- R10: After reset, all capture registers, flags, event pulses and the interrupt request are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 9 | Candidate pin inputs, asynchronous |
| ch_en_i | input | 3 | Per-channel capture enable |
| pin_sel_i | input | 12 | Per-channel 4-bit pin select, channel c at bits 4c+3:4c |
| edge_mode_i | input | 6 | Per-channel 2-bit edge mode, channel c at bits 2c+1:2c |
| filt_en_i | input | 3 | Per-channel glitch filter enable |
| timer_i | input | 16 | Shared running timer value |
| flag_clr_i | input | 3 | Per-channel flag clear, one cycle |
| irq_en_i | input | 1 | Capture interrupt enable |
| glb_en_i | input | 1 | Global interrupt enable |
| cap_o | output | 48 | Capture registers, channel c at bits 16c+15:16c |
| flag_o | output | 3 | Sticky capture flags |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | 3 | Per-channel capture event pulse |

## Verification
An unfiltered capture is due 4 edges after the pin change and a filtered one 7 edges after it. A flag clear acts on the next edge. The interrupt follows flags and enables in the same cycle. For each expected capture, the driver records the channel, the timer value and the exact cycle in which the capture is due. The monitor samples at the falling clock edge and compares the cycle of every event pulse with that record, together with the register contents and the flag. Events nobody expected, and expected events still pending once a stimulus has settled, both count as miscompares.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDG_FALL = 2'b00,
    EDG_RISE = 2'b01,
    EDG_BOTH = 2'b10,
    EDG_OFF  = 2'b11
  } edge_mode_t;
endpackage

// File: rtl/cap_front.sv
// Pin selection, two-flop synchronizer and optional stability filter.
module cap_front #(
  parameter int NPINS  = 9,
  parameter int SELW   = 4,
  parameter int STABLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [SELW-1:0]  sel,
  input  logic             filt_en,
  output logic             lvl
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

  logic          picked;
  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (sel == SELW'(i)) picked = pins[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], picked};
  end

  // Filtered level moves only after the synchronized input has
  // differed from it for STABLE consecutive cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!filt_en || sync_q[1] == filt_q) begin
      filt_q <= sync_q[1];
      cnt_q  <= '0;
    end else if (cnt_q == CW'(STABLE - 1)) begin
      filt_q <= sync_q[1];
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign lvl = filt_q;
endmodule

// File: rtl/cap_chan.sv
// Edge qualification, capture register, sticky flag and event pulse.
module cap_chan
  import cap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [TW-1:0] timer,
  input  logic          clr,
  output logic [TW-1:0] cap,
  output logic          flag,
  output logic          evt
);
  logic prev_q;
  logic rise, fall, hit;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    case (edge_mode_t'(mode))
      EDG_FALL: hit = fall;
      EDG_RISE: hit = rise;
      EDG_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    hit = hit & en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap    <= '0;
      flag   <= 1'b0;
      evt    <= 1'b0;
    end else begin
      prev_q <= lvl;
      evt    <= hit;
      if (hit) cap <= timer;
      flag   <= (flag & ~clr) | hit;
    end
  end
endmodule

// File: rtl/cap3_unit.sv
module cap3_unit #(
  parameter int NCH    = 3,
  parameter int NPINS  = 9,
  parameter int SELW   = 4,
  parameter int TW     = 16,
  parameter int STABLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH*SELW-1:0] pin_sel_i,
  input  logic [NCH*2-1:0]  edge_mode_i,
  input  logic [NCH-1:0]    filt_en_i,
  input  logic [TW-1:0]     timer_i,
  input  logic [NCH-1:0]    flag_clr_i,
  input  logic              irq_en_i,
  input  logic              glb_en_i,
  output logic [NCH*TW-1:0] cap_o,
  output logic [NCH-1:0]    flag_o,
  output logic              irq_o,
  output logic [NCH-1:0]    evt_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic lvl;

    cap_front #(.NPINS(NPINS), .SELW(SELW), .STABLE(STABLE)) front_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (pins_i),
      .sel     (pin_sel_i[c*SELW +: SELW]),
      .filt_en (filt_en_i[c]),
      .lvl     (lvl)
    );

    cap_chan #(.TW(TW)) chan_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .en    (ch_en_i[c]),
      .mode  (edge_mode_i[c*2 +: 2]),
      .timer (timer_i),
      .clr   (flag_clr_i[c]),
      .cap   (cap_o[c*TW +: TW]),
      .flag  (flag_o[c]),
      .evt   (evt_o[c])
    );
  end

  assign irq_o = (|flag_o) & irq_en_i & glb_en_i;
endmodule

// File: rtl/cap3_unit_chk.sv
module cap3_unit_chk #(
  parameter int NCH = 3,
  parameter int TW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ch_en_i,
  input logic [NCH*2-1:0]  edge_mode_i,
  input logic [TW-1:0]     timer_i,
  input logic [NCH-1:0]    flag_clr_i,
  input logic              irq_en_i,
  input logic              glb_en_i,
  input logic [NCH*TW-1:0] cap_o,
  input logic [NCH-1:0]    flag_o,
  input logic              irq_o,
  input logic [NCH-1:0]    evt_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R2
    evt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[c] |-> cap_o[c*TW +: TW] == $past(timer_i));
    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en_i[c] |=> !evt_o[c]);
    // R3
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i[c*2 +: 2] == 2'b11) |=> !evt_o[c]);
    // R6
    flag_on_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[c] |-> flag_o[c]);
    // R6
    flag_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o[c]) |-> $past(flag_clr_i[c]));
    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_o[c] |-> $stable(cap_o[c*TW +: TW]));
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_en_i && glb_en_i) |-> !irq_o);
  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o != '0 && irq_en_i && glb_en_i) |-> irq_o);
endmodule

bind cap3_unit cap3_unit_chk #(.NCH(NCH), .TW(TW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_en_i     (ch_en_i),
  .edge_mode_i (edge_mode_i),
  .timer_i     (timer_i),
  .flag_clr_i  (flag_clr_i),
  .irq_en_i    (irq_en_i),
  .glb_en_i    (glb_en_i),
  .cap_o       (cap_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .evt_o       (evt_o)
);

// File: tb/cap3_unit_tb_top.sv
`timescale 1ns/1ps
module cap3_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  pins_i = '0;
  logic [2:0]  ch_en_i = '0;
  logic [11:0] pin_sel_i = '0;
  logic [5:0]  edge_mode_i = '0;
  logic [2:0]  filt_en_i = '0;
  logic [15:0] timer_i = '0;
  logic [2:0]  flag_clr_i = '0;
  logic        irq_en_i = 1'b0;
  logic        glb_en_i = 1'b0;
  logic [47:0] cap_o;
  logic [2:0]  flag_o;
  logic        irq_o;
  logic [2:0]  evt_o;

  cap3_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .ch_en_i(ch_en_i),
    .pin_sel_i(pin_sel_i), .edge_mode_i(edge_mode_i), .filt_en_i(filt_en_i),
    .timer_i(timer_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .glb_en_i(glb_en_i), .cap_o(cap_o), .flag_o(flag_o), .irq_o(irq_o),
    .evt_o(evt_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          ch;
    logic [15:0] val;
    int          due;
    string       req;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  string phase = "R10";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: record an expected capture due 4 (raw) or 7 (filtered) edges on.
  task automatic expect_cap(int ch, logic [15:0] v, bit filt, string req);
    exp_t e;
    e.ch = ch; e.val = v; e.due = cyc + (filt ? 7 : 4); e.req = req;
    q.push_back(e);
  endtask

  task automatic quiet(string req);
    chk(q.size() == 0, req, "expected captures still pending", q.size(), 0);
    q.delete();
  endtask

  // Monitor: compare every event pulse against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 3; c++) begin
        if (evt_o[c]) begin
          if (q.size() == 0) begin
            chk(1'b0, phase, "unexpected capture on channel", c, 32'hffff_ffff);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.ch == c, e.req, "capture channel", c, e.ch);
            chk(cyc == e.due, "R8", "capture cycle", cyc, e.due);
            chk(cap_o[c*16 +: 16] == e.val, e.req, "captured value", cap_o[c*16 +: 16], e.val);
            chk(flag_o[c], "R6", "flag after capture", flag_o[c], 1);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    chk(cap_o == '0, "R10", "capture regs", cap_o[31:0], 0);
    chk(flag_o == '0, "R10", "flags", flag_o, 0);
    chk(irq_o == 1'b0, "R10", "irq", irq_o, 0);
    chk(evt_o == '0, "R10", "events", evt_o, 0);

    // ch0: pin 3 rising, ch1: pin 8 falling, ch2: pin 0 both
    ch_en_i     = 3'b111;
    pin_sel_i   = {4'd0, 4'd8, 4'd3};
    edge_mode_i = {2'b10, 2'b00, 2'b01};
    tick(4);

    // R2 R1 rising capture on ch0
    phase = "R2"; timer_i = 16'h1234;
    pins_i[3] = 1'b1; expect_cap(0, 16'h1234, 0, "R2");
    tick(8); quiet("R2");
    phase = "R3"; timer_i = 16'h4321;
    pins_i[3] = 1'b0; tick(8); quiet("R3");
    chk(cap_o[15:0] == 16'h1234, "R3", "ch0 holds on falling edge", cap_o[15:0], 16'h1234);

    // R3 falling mode on ch1 via pin 8
    timer_i = 16'hBEEF;
    pins_i[8] = 1'b1; tick(8); quiet("R3");
    pins_i[8] = 1'b0; expect_cap(1, 16'hBEEF, 0, "R1");
    tick(8); quiet("R1");

    // R3 R9 both edges on ch2, second capture while flag still set
    timer_i = 16'h0111;
    pins_i[0] = 1'b1; expect_cap(2, 16'h0111, 0, "R3");
    tick(8);
    timer_i = 16'h0222;
    pins_i[0] = 1'b0; expect_cap(2, 16'h0222, 0, "R9");
    tick(8); quiet("R9");
    chk(cap_o[47:32] == 16'h0222, "R9", "ch2 overwritten", cap_o[47:32], 16'h0222);

    // R1 out-of-range select gives no capture
    phase = "R1"; pin_sel_i[3:0] = 4'd9; timer_i = 16'h9999;
    pins_i[3] = 1'b1; tick(8); pins_i[3] = 1'b0; tick(8); quiet("R1");
    chk(cap_o[15:0] == 16'h1234, "R1", "ch0 untouched by select 9", cap_o[15:0], 16'h1234);
    pin_sel_i[3:0] = 4'd3; tick(4);

    // R4 disabled channel
    phase = "R4"; ch_en_i[0] = 1'b0; timer_i = 16'h5555;
    pins_i[3] = 1'b1; tick(8); pins_i[3] = 1'b0; tick(8); quiet("R4");
    chk(cap_o[15:0] == 16'h1234, "R4", "ch0 untouched while disabled", cap_o[15:0], 16'h1234);
    ch_en_i[0] = 1'b1;

    // R3 mode 11 disables
    phase = "R3"; edge_mode_i[1:0] = 2'b11;
    pins_i[3] = 1'b1; tick(8); pins_i[3] = 1'b0; tick(8); quiet("R3");
    chk(cap_o[15:0] == 16'h1234, "R3", "ch0 untouched in mode 11", cap_o[15:0], 16'h1234);
    edge_mode_i[1:0] = 2'b01;

    // R5 filter: 3-clock glitch dropped, 4-clock pulse accepted
    phase = "R5"; filt_en_i[0] = 1'b1; timer_i = 16'h0AAA; tick(2);
    pins_i[3] = 1'b1; tick(3); pins_i[3] = 1'b0; tick(12); quiet("R5");
    chk(cap_o[15:0] == 16'h1234, "R5", "glitch rejected", cap_o[15:0], 16'h1234);
    pins_i[3] = 1'b1; expect_cap(0, 16'h0AAA, 1, "R5");
    tick(4); pins_i[3] = 1'b0; tick(12); quiet("R5");
    filt_en_i[0] = 1'b0;

    // R6 R7 clear, interrupt gating, set-wins
    phase = "R6";
    flag_clr_i = 3'b111; tick(1); flag_clr_i = 3'b000; tick(1);
    chk(flag_o == 3'b000, "R6", "flags cleared", flag_o, 0);
    irq_en_i = 1'b1; glb_en_i = 1'b1; #1;
    chk(irq_o == 1'b0, "R7", "irq with no flag", irq_o, 0);
    tick(1);
    pins_i[8] = 1'b1; tick(8);
    timer_i = 16'h7777;
    pins_i[8] = 1'b0; expect_cap(1, 16'h7777, 0, "R6");
    tick(3); flag_clr_i[1] = 1'b1; tick(1); flag_clr_i[1] = 1'b0;
    chk(flag_o[1] == 1'b1, "R6", "set beats clear", flag_o[1], 1);
    chk(irq_o == 1'b1, "R7", "irq raised", irq_o, 1);
    glb_en_i = 1'b0; #1;
    chk(irq_o == 1'b0, "R7", "irq masked by global enable", irq_o, 0);
    glb_en_i = 1'b1; irq_en_i = 1'b0; #1;
    chk(irq_o == 1'b0, "R7", "irq masked by capture enable", irq_o, 0);
    irq_en_i = 1'b1;
    tick(1); flag_clr_i[1] = 1'b1; tick(1); flag_clr_i[1] = 1'b0;
    chk(flag_o == 3'b000, "R6", "flag cleared by software", flag_o, 0);
    chk(irq_o == 1'b0, "R7", "irq drops with flags", irq_o, 0);
    tick(4); quiet("R6");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule